// File: doc/BRIEF.md
# Class-of-Service Cache Mask Table

This block stores cache way-allocation masks for two cache levels, a last-level cache (L3) and a mid-level cache (L2), indexed by a class-of-service (COS) number. A configuration agent programs masks through a single write port; each write is validated and answered with a one-cycle error pulse when it breaks a rule. A lookup port takes the COS of the running thread plus an access type (code or data) and returns, one cycle later, the way masks that the L2 and L3 allocation logic must honour.

The L3 table has two interpretations. In the plain mode, each COS owns one L3 mask used for both code and data fetches. In the split mode, the L3 entries are grouped as pairs, so each class gets a separate data mask (even entry) and code mask (odd entry), and only the lower half of the COS range remains meaningful for L3. The L2 table ignores this mode. Both levels share the COS input; a COS past a level's table size makes that level return its all-ones default, while the other level still returns its own entry.

Top module: `cos_mask_table`

## Requirements
- R1: Entry 0 of each level always reads as the all-ones mask of that level's width; a write to entry 0 raises an error and leaves it unchanged, and COS 0 in plain mode looks up all ones.
- R2: A write whose mask is not a single contiguous run of ones raises an error and the stored entry keeps its previous value.
- R3: A write of an all-zero mask, or of a mask with a bit set at or above the target level's mask width, raises an error and changes nothing.
- R4: A write whose index is not below the target level's entry count raises an error; a lookup COS not below the L3 entry count returns the L3 all-ones mask.
- R5: In plain mode the L3 output for COS c is entry c for both code and data (lk_code_i has no effect); outputs are registered with one cycle of latency, and a lookup in the same cycle as a write to the looked-up entry returns the old value, the next lookup the new one.
- R6: In split mode, a data lookup (lk_code_i=0) of COS c returns L3 entry 2c and a code lookup (lk_code_i=1) returns entry 2c+1; a COS not below half the L3 entry count returns the L3 all-ones mask.
- R7: The L2 output for COS c is L2 entry c regardless of mode and access type; a COS not below the L2 entry count returns the L2 all-ones mask while L3 still returns its own entry.
- R8: After reset the mode is plain, every entry holds all ones, both outputs are all ones and the error output is low.
- R9: Write target encoding wr_target_i: 0 = L2 entry, 1 = L3 entry, 2 = mode (split mode set to wr_mask_i[0], never an error), 3 = reserved and always an error; wr_err_o is a single-cycle pulse in the cycle after the offending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_target_i | input | 2 | Write target (L2, L3, mode, reserved) |
| wr_idx_i | input | COS_W | Raw table entry index for the write |
| wr_mask_i | input | WR_W | Mask to store, or mode bit in bit 0 |
| wr_err_o | output | 1 | Rejected-write pulse, one cycle after the write |
| lk_cos_i | input | COS_W | Class of service to look up |
| lk_code_i | input | 1 | Access type: 1 code fetch, 0 data |
| l2_mask_o | output | L2_MASK_W | Effective L2 way mask |
| l3_mask_o | output | L3_MASK_W | Effective L3 way mask |

## Verification
A write and a lookup can land in the same cycle, including a lookup of the very entry being written and a lookup coinciding with a mode change. The bench drives a write and a lookup of the same COS on one edge and expects the old mask, then repeats the lookup alone and expects the new one. Mode-dependent re-pairing is judged by programming adjacent L3 entries with distinct runs and checking that code and data lookups pick the odd and even entry only in split mode, while L2 stays unchanged.

// File: rtl/cos_mask_pkg.sv
package cos_mask_pkg;

  typedef enum logic [1:0] {
    TGT_L2   = 2'd0,
    TGT_L3   = 2'd1,
    TGT_MODE = 2'd2,
    TGT_RSVD = 2'd3
  } wr_target_e;

  // Non-zero and one contiguous run: adding the lowest set bit clears the run.
  function automatic logic is_run(input logic [31:0] m);
    logic [31:0] low;
    low = m & (~m + 32'd1);
    return (m != 32'd0) && (((m + low) & m) == 32'd0);
  endfunction

endpackage

// File: rtl/cos_mask_wr_check.sv
module cos_mask_wr_check
  import cos_mask_pkg::*;
#(
  parameter int L2_ENTRIES = 8,
  parameter int L3_ENTRIES = 16,
  parameter int L2_MASK_W  = 8,
  parameter int L3_MASK_W  = 12,
  parameter int COS_W      = 5,
  parameter int WR_W       = 12
) (
  input  logic             wr_en_i,
  input  logic [1:0]       wr_target_i,
  input  logic [COS_W-1:0] wr_idx_i,
  input  logic [WR_W-1:0]  wr_mask_i,
  output logic             l2_we_o,
  output logic             l3_we_o,
  output logic             mode_we_o,
  output logic             err_o
);

  logic l2_ok, l3_ok;

  always_comb begin
    l2_ok = (wr_idx_i != '0) && (wr_idx_i < COS_W'(L2_ENTRIES))
            && ((wr_mask_i >> L2_MASK_W) == '0) && is_run(32'(wr_mask_i));
    l3_ok = (wr_idx_i != '0) && (wr_idx_i < COS_W'(L3_ENTRIES))
            && ((wr_mask_i >> L3_MASK_W) == '0) && is_run(32'(wr_mask_i));
  end

  always_comb begin
    l2_we_o   = 1'b0;
    l3_we_o   = 1'b0;
    mode_we_o = 1'b0;
    err_o     = 1'b0;
    if (wr_en_i) begin
      case (wr_target_e'(wr_target_i))
        TGT_L2:   begin l2_we_o = l2_ok; err_o = !l2_ok; end
        TGT_L3:   begin l3_we_o = l3_ok; err_o = !l3_ok; end
        TGT_MODE: mode_we_o = 1'b1;
        default:  err_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cos_mask_level.sv
module cos_mask_level #(
  parameter int ENTRIES = 8,
  parameter int MASK_W  = 8,
  parameter int IDX_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [MASK_W-1:0] rd_mask_o
);

  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [MASK_W-1:0] ONES = '1;

  logic [MASK_W-1:0] tab [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= ONES;
    end else if (we_i) begin
      for (int i = 1; i < ENTRIES; i++)
        if (wr_idx_i == IDX_W'(i)) tab[i] <= wr_mask_i;
    end
  end

  always_comb begin
    if (rd_idx_i < IDX_W'(ENTRIES)) rd_mask_o = tab[rd_idx_i[AW-1:0]];
    else                            rd_mask_o = ONES;
  end

  // The validator must never let a write reach entry 0 or past the table.
  assert_we_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wr_idx_i != '0) && (wr_idx_i < IDX_W'(ENTRIES)));

endmodule

// File: rtl/cos_mask_table.sv
module cos_mask_table
  import cos_mask_pkg::*;
#(
  parameter  int L2_ENTRIES = 8,
  parameter  int L3_ENTRIES = 16,
  parameter  int L2_MASK_W  = 8,
  parameter  int L3_MASK_W  = 12,
  localparam int COS_W      = $clog2(L3_ENTRIES) + 1,
  localparam int WR_W       = (L2_MASK_W > L3_MASK_W) ? L2_MASK_W : L3_MASK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_target_i,
  input  logic [COS_W-1:0]     wr_idx_i,
  input  logic [WR_W-1:0]      wr_mask_i,
  output logic                 wr_err_o,
  input  logic [COS_W-1:0]     lk_cos_i,
  input  logic                 lk_code_i,
  output logic [L2_MASK_W-1:0] l2_mask_o,
  output logic [L3_MASK_W-1:0] l3_mask_o
);

  localparam logic [L2_MASK_W-1:0] L2_ONES = '1;
  localparam logic [L3_MASK_W-1:0] L3_ONES = '1;
  localparam logic [COS_W-1:0]     HALF    = COS_W'(L3_ENTRIES / 2);

  logic l2_we, l3_we, mode_we, wr_err;
  logic split_q;
  logic [COS_W-1:0]     l3_rd_idx;
  logic [L2_MASK_W-1:0] l2_rd;
  logic [L3_MASK_W-1:0] l3_rd;
  logic                 l3_oob_split;

  cos_mask_wr_check #(
    .L2_ENTRIES(L2_ENTRIES), .L3_ENTRIES(L3_ENTRIES),
    .L2_MASK_W(L2_MASK_W), .L3_MASK_W(L3_MASK_W),
    .COS_W(COS_W), .WR_W(WR_W)
  ) u_check (
    .wr_en_i    (wr_en_i),
    .wr_target_i(wr_target_i),
    .wr_idx_i   (wr_idx_i),
    .wr_mask_i  (wr_mask_i),
    .l2_we_o    (l2_we),
    .l3_we_o    (l3_we),
    .mode_we_o  (mode_we),
    .err_o      (wr_err)
  );

  cos_mask_level #(.ENTRIES(L2_ENTRIES), .MASK_W(L2_MASK_W), .IDX_W(COS_W)) u_l2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (l2_we),
    .wr_idx_i (wr_idx_i),
    .wr_mask_i(wr_mask_i[L2_MASK_W-1:0]),
    .rd_idx_i (lk_cos_i),
    .rd_mask_o(l2_rd)
  );

  // Split mode re-pairs L3 entries: even = data, odd = code.
  assign l3_rd_idx    = split_q ? {lk_cos_i[COS_W-2:0], lk_code_i} : lk_cos_i;
  assign l3_oob_split = split_q && (lk_cos_i >= HALF);

  cos_mask_level #(.ENTRIES(L3_ENTRIES), .MASK_W(L3_MASK_W), .IDX_W(COS_W)) u_l3 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (l3_we),
    .wr_idx_i (wr_idx_i),
    .wr_mask_i(wr_mask_i[L3_MASK_W-1:0]),
    .rd_idx_i (l3_rd_idx),
    .rd_mask_o(l3_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      split_q   <= 1'b0;
      wr_err_o  <= 1'b0;
      l2_mask_o <= L2_ONES;
      l3_mask_o <= L3_ONES;
    end else begin
      wr_err_o  <= wr_err;
      l2_mask_o <= l2_rd;
      l3_mask_o <= l3_oob_split ? L3_ONES : l3_rd;
      if (mode_we) split_q <= wr_mask_i[0];
    end
  end

  assert_cos0_default_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_cos_i == '0) && !split_q |=> (l3_mask_o == L3_ONES) && (l2_mask_o == L2_ONES));

  assert_l3_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_run(32'(l3_mask_o)) && is_run(32'(l2_mask_o)));

  assert_split_oob_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_q && (lk_cos_i >= HALF) |=> (l3_mask_o == L3_ONES));

  assert_l2_oob_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_cos_i >= COS_W'(L2_ENTRIES)) |=> (l2_mask_o == L2_ONES));

  assert_err_after_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i));

  assert_one_action_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l2_we, l3_we, mode_we, wr_err}));

endmodule

// File: tb/cos_mask_table_tb.sv
module cos_mask_table_tb;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_target = '0;
  logic [4:0]  wr_idx = '0;
  logic [11:0] wr_mask = '0;
  logic        wr_err;
  logic [4:0]  lk_cos = '0;
  logic        lk_code = 1'b0;
  logic [7:0]  l2_mask;
  logic [11:0] l3_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cos_mask_table u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_target_i(wr_target), .wr_idx_i(wr_idx),
    .wr_mask_i(wr_mask), .wr_err_o(wr_err),
    .lk_cos_i(lk_cos), .lk_code_i(lk_code),
    .l2_mask_o(l2_mask), .l3_mask_o(l3_mask)
  );

  // {target, index, mask, expected error}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 5'd3,  12'h0F0, 1'b0},
    {2'd1, 5'd0,  12'h00F, 1'b1},  // R1 entry 0
    {2'd1, 5'd5,  12'h0A0, 1'b1},  // R2 split run
    {2'd1, 5'd5,  12'h000, 1'b1},  // R3 zero
    {2'd0, 5'd2,  12'h100, 1'b1},  // R3 above L2 width
    {2'd0, 5'd8,  12'h003, 1'b1},  // R4 L2 index
    {2'd1, 5'd16, 12'h003, 1'b1},  // R4 L3 index
    {2'd0, 5'd2,  12'h03C, 1'b0},
    {2'd3, 5'd2,  12'h001, 1'b1},  // R9 reserved target
    {2'd1, 5'd6,  12'h00F, 1'b0},
    {2'd1, 5'd7,  12'hF00, 1'b0},
    {2'd0, 5'd7,  12'h080, 1'b0},
    {2'd1, 5'd11, 12'h7E0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] t, input logic [4:0] i, input logic [11:0] m,
                          input logic exp_err, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_target = t; wr_idx = i; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
    check(req, 32'(wr_err), 32'(exp_err));
  endtask

  task automatic do_lookup(input logic [4:0] c, input logic code,
                           input logic [7:0] e2, input logic [11:0] e3, input string req);
    @(negedge clk);
    lk_cos = c; lk_code = code;
    @(negedge clk);
    check({req, " l2"}, 32'(l2_mask), 32'(e2));
    check({req, " l3"}, 32'(l3_mask), 32'(e3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 l2 reset", 32'(l2_mask), 32'hFF);
    check("R8 l3 reset", 32'(l3_mask), 32'hFFF);
    check("R8 err reset", 32'(wr_err), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      do_write(VEC[v][19:18], VEC[v][17:13], VEC[v][12:1], VEC[v][0], "R9 vector error");

    // R9 pulse lasts one cycle
    do_write(2'd3, 5'd1, 12'h1, 1'b1, "R9 reserved");
    @(negedge clk);
    check("R9 pulse width", 32'(wr_err), 32'd0);

    do_lookup(5'd3, 1'b0, 8'hFF, 12'h0F0, "R5 data");
    do_lookup(5'd3, 1'b1, 8'hFF, 12'h0F0, "R5 code");
    do_lookup(5'd2, 1'b0, 8'h3C, 12'hFFF, "R7 l2 entry");
    do_lookup(5'd5, 1'b0, 8'hFF, 12'hFFF, "R2 R3 unchanged");
    do_lookup(5'd0, 1'b1, 8'hFF, 12'hFFF, "R1 cos0");
    do_lookup(5'd11, 1'b0, 8'hFF, 12'h7E0, "R7 l2 oob");
    do_lookup(5'd16, 1'b0, 8'hFF, 12'hFFF, "R4 l3 oob");

    // R5 write and lookup of the same entry in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_target = 2'd1; wr_idx = 5'd4; wr_mask = 12'h00C;
    lk_cos = 5'd4; lk_code = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5 same cycle old", 32'(l3_mask), 32'hFFF);
    check("R5 same cycle err", 32'(wr_err), 32'd0);
    @(negedge clk);
    check("R5 next lookup new", 32'(l3_mask), 32'h00C);

    // R6 split mode
    do_write(2'd2, 5'd0, 12'h001, 1'b0, "R9 mode write");
    do_lookup(5'd3, 1'b0, 8'hFF, 12'h00F, "R6 data even");
    do_lookup(5'd3, 1'b1, 8'hFF, 12'hF00, "R6 code odd");
    do_lookup(5'd2, 1'b0, 8'h3C, 12'h00C, "R6 R7 data");
    do_lookup(5'd2, 1'b1, 8'h3C, 12'hFFF, "R6 R7 code");
    do_lookup(5'd8, 1'b0, 8'hFF, 12'hFFF, "R6 upper half");
    do_lookup(5'd7, 1'b1, 8'h80, 12'hFFF, "R7 l2 in split");
    do_lookup(5'd11, 1'b0, 8'hFF, 12'hFFF, "R6 cos11 split");

    // back to plain
    do_write(2'd2, 5'd0, 12'h000, 1'b0, "R9 mode clear");
    do_lookup(5'd3, 1'b1, 8'hFF, 12'h0F0, "R5 plain again");
    do_lookup(5'd11, 1'b1, 8'hFF, 12'h7E0, "R5 plain cos11");

    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 200000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule